// File: doc/BRIEF.md
# Symbol-Rate Ratio Reducer

This block turns a requested symbol rate, given in hertz, into a reduced fraction for a fractional resampler. The resampler runs from a fixed 9 MHz reference, so the raw fraction is the symbol rate over 9,000,000. The block finds the greatest common divisor of the two terms with a binary shift-and-subtract method and divides both terms by it exactly with a multi-cycle restoring divider. It then halves both terms together until each fits a 27-bit register field.

A resampler cannot use a denominator that is a power of two. The block flags an error when the final denominator is one, zero or any single power of two. A zero symbol rate is rejected at once, without running the divisor search. Control is a plain start/busy/done handshake: the caller raises `start` for one cycle with the rate on `sym_rate`, waits for the single-cycle `done` pulse, and reads `ratio_num`, `ratio_den` and `bad_ratio`. Those outputs hold until the next accepted start.

Top module: `rate_ratio_reducer`

## Requirements
- R1: After reset, `busy`, `done` and `bad_ratio` are 0, and `ratio_num` and `ratio_den` are 0.
- R2: A `start` with a nonzero `sym_rate` in an idle cycle is accepted, and `busy` is 1 in the following cycle. `busy` stays 1 until the cycle in which `done` is 1, and `busy` is 0 in that cycle.
- R3: Let g be the greatest common divisor of `sym_rate` and 9,000,000. If both `sym_rate`/g and 9,000,000/g are at most 0x07FFFFFF, then `ratio_num` is `sym_rate`/g and `ratio_den` is 9,000,000/g.
- R4: If either quotient exceeds 0x07FFFFFF, both quotients are shifted right by one bit together, repeatedly, until neither exceeds 0x07FFFFFF.
- R5: `bad_ratio` is 1 at `done` exactly when the final `ratio_den` has at most one bit set. That case covers a power of two, including 1. Otherwise `bad_ratio` is 0.
- R6: A `start` with `sym_rate` equal to 0 gives `done`=1 in the next cycle, with `bad_ratio`=1 and both ratio outputs 0. `busy` stays 0 throughout.
- R7: A `start` while `busy` is 1 is ignored. The result is the one for the rate accepted earlier.
- R8: `done` is 1 for exactly one cycle per accepted start. The ratio outputs and `bad_ratio` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to reduce `sym_rate` |
| sym_rate | input | 32 | Requested symbol rate in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| ratio_num | output | 32 | Reduced numerator |
| ratio_den | output | 32 | Reduced denominator |
| bad_ratio | output | 1 | Zero rate, or denominator is a power of two |

## Verification
The zero-rate case has a fixed latency: `done` is due one cycle after `start`, and the bench samples it at that cycle's falling edge. For a nonzero rate, the bench checks `busy` at the first falling edge after `start`. The total latency of a nonzero rate depends on the operand values. The bench therefore polls on falling edges until `done`, within a bounded cycle count. It compares all results in that `done` cycle and confirms at the next falling edge that `done` has dropped. Held outputs are rechecked several cycles later. A start issued mid-computation is followed through to the same `done` pulse, to confirm it had no effect.

// File: rtl/rate_ratio_reducer.sv
module rate_ratio_reducer #(
  parameter int W = 32,
  parameter logic [W-1:0] REF_HZ = 9000000,
  parameter logic [W-1:0] LIMIT = 32'h07FFFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] sym_rate,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ratio_num,
  output logic [W-1:0] ratio_den,
  output logic         bad_ratio
);
  localparam int CW = $clog2(W);
  localparam int KW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [2:0] {S_IDLE, S_PAIR, S_ODDU, S_GCD, S_DIV, S_FIT} st_t;
  st_t state;

  logic [W-1:0] u, v, num, g, dvd, quo;
  logic [W:0]   rem;
  logic [KW-1:0] k;
  logic [CW-1:0] cnt;
  logic          sel;

  logic [W-1:0] lo, hi, diff;
  assign lo   = (u < v) ? u : v;
  assign hi   = (u < v) ? v : u;
  assign diff = hi - lo;

  logic [W:0]   rem_sh, rem_nx;
  logic         fits;
  logic [W-1:0] quo_nx;
  assign rem_sh = {rem[W-1:0], dvd[W-1]};
  assign fits   = rem_sh >= {1'b0, g};
  assign rem_nx = fits ? rem_sh - {1'b0, g} : rem_sh;
  assign quo_nx = {quo[W-2:0], fits};

  logic too_big;
  assign too_big = (ratio_num > LIMIT) || (ratio_den > LIMIT);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0;
      bad_ratio <= 1'b0;
      ratio_num <= '0;
      ratio_den <= '0;
      u <= '0; v <= '0; num <= '0; g <= '0;
      dvd <= '0; quo <= '0; rem <= '0;
      k <= '0; cnt <= '0; sel <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (sym_rate == '0) begin
            done <= 1'b1;
            bad_ratio <= 1'b1;
            ratio_num <= '0;
            ratio_den <= '0;
          end else begin
            u <= sym_rate;
            v <= REF_HZ;
            num <= sym_rate;
            k <= '0;
            state <= S_PAIR;
          end
        end
        S_PAIR: begin
          if (!u[0] && !v[0]) begin
            u <= u >> 1;
            v <= v >> 1;
            k <= k + 1'b1;
          end else begin
            state <= S_ODDU;
          end
        end
        S_ODDU: begin
          if (!u[0]) u <= u >> 1;
          else state <= S_GCD;
        end
        S_GCD: begin
          if (!v[0]) begin
            v <= v >> 1;
          end else begin
            u <= lo;
            v <= diff;
            if (diff == '0) begin
              g <= lo << k;
              dvd <= num;
              rem <= '0;
              quo <= '0;
              cnt <= '0;
              sel <= 1'b0;
              state <= S_DIV;
            end
          end
        end
        S_DIV: begin
          rem <= rem_nx;
          quo <= quo_nx;
          dvd <= dvd << 1;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            rem <= '0;
            quo <= '0;
            cnt <= '0;
            if (!sel) begin
              ratio_num <= quo_nx;
              dvd <= REF_HZ;
              sel <= 1'b1;
            end else begin
              ratio_den <= quo_nx;
              state <= S_FIT;
            end
          end
        end
        S_FIT: begin
          if (too_big) begin
            ratio_num <= ratio_num >> 1;
            ratio_den <= ratio_den >> 1;
          end else begin
            bad_ratio <= ($countones(ratio_den) <= 1);
            done <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  hold_rate_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(num));
  // R3
  exact_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV && cnt == LAST) |-> (rem_nx == '0));
  // R4
  fit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_ratio) |-> (ratio_num <= LIMIT && ratio_den <= LIMIT));
  // R5
  den_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_ratio) |-> ($countones(ratio_den) > 1));
  // R6
  zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && sym_rate == '0) |=> (done && bad_ratio && !busy));
endmodule

// File: tb/sim_rate_ratio_reducer.sv
module sim_rate_ratio_reducer;
  localparam int PERIOD = 10;
  localparam int N = 12;
  localparam logic [31:0] TBL [0:N-1][0:3] = '{
    '{32'd6900000,    32'd23,         32'd30,      32'd0},
    '{32'd1000000,    32'd1,          32'd9,       32'd0},
    '{32'd7100000,    32'd71,         32'd90,      32'd0},
    '{32'd6875000,    32'd55,         32'd72,      32'd0},
    '{32'd4500000,    32'd1,          32'd2,       32'd1},
    '{32'd9000000,    32'd1,          32'd1,       32'd1},
    '{32'd7031250,    32'd25,         32'd32,      32'd1},
    '{32'd1,          32'd1,          32'd9000000, 32'd0},
    '{32'd3,          32'd1,          32'd3000000, 32'd0},
    '{32'h80000000,   32'd33554432,   32'd140625,  32'd0},
    '{32'h10000000,   32'd4194304,    32'd140625,  32'd0},
    '{32'hFFFFFFFF,   32'h04444444,   32'd150000,  32'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] sym_rate = '0;
  logic busy, done, bad_ratio;
  logic [31:0] ratio_num, ratio_den;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rate_ratio_reducer u0 (.clk(clk), .rst_n(rst_n), .start(start), .sym_rate(sym_rate),
    .busy(busy), .done(done), .ratio_num(ratio_num), .ratio_den(ratio_den),
    .bad_ratio(bad_ratio));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] r);
    @(negedge clk);
    start = 1'b1;
    sym_rate = r;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 err", {31'd0, bad_ratio}, 32'd0);
    check("R1 num", ratio_num, 32'd0);
    check("R1 den", ratio_den, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      pulse(TBL[i][0]);
      check("R2 busy after start", {31'd0, busy}, 32'd1);
      wait_done(cyc);
      check("R2 done seen", {31'd0, done}, 32'd1);
      check("R2 busy low at done", {31'd0, busy}, 32'd0);
      check("R3 R4 num", ratio_num, TBL[i][1]);
      check("R3 R4 den", ratio_den, TBL[i][2]);
      check("R5 err", {31'd0, bad_ratio}, TBL[i][3]);
      @(negedge clk);
      check("R8 done single", {31'd0, done}, 32'd0);
    end

    // R8 hold after done
    repeat (5) @(negedge clk);
    check("R8 hold num", ratio_num, 32'h04444444);
    check("R8 hold den", ratio_den, 32'd150000);

    // R6 zero rate
    pulse(32'd0);
    check("R6 done next cycle", {31'd0, done}, 32'd1);
    check("R6 busy", {31'd0, busy}, 32'd0);
    check("R6 err", {31'd0, bad_ratio}, 32'd1);
    check("R6 num", ratio_num, 32'd0);
    check("R6 den", ratio_den, 32'd0);
    @(negedge clk);
    check("R6 R8 done drops", {31'd0, done}, 32'd0);

    // R7 start while busy ignored
    pulse(32'd6900000);
    @(negedge clk);
    start = 1'b1;
    sym_rate = 32'd1000000;
    @(negedge clk);
    start = 1'b0;
    sym_rate = 32'd0;
    wait_done(cyc);
    check("R7 num", ratio_num, 32'd23);
    check("R7 den", ratio_den, 32'd30);
    check("R7 err", {31'd0, bad_ratio}, 32'd0);
    repeat (4) @(negedge clk);
    check("R7 no second done", {31'd0, busy | done}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule